// File: doc/BRIEF.md
# Time-Averaged XOR Phase Readout

This block measures how closely two frequency-locked oscillator waveforms agree in phase. Each waveform arrives as a single bit that an external comparator has already thresholded. The block brings both bits into the sample-clock domain and compares them with an XOR on every sample. It also marks each rising edge of the first input as the start of an oscillator cycle.

After a start request, the block waits for the first cycle boundary. It then accumulates over a whole number of oscillator cycles, set by a window-length input. It keeps two counts: the number of samples in the window and the number of samples where the bits disagree. When the window closes, a sequential divider forms the complement of the disagreement duty as an unsigned 16-bit fraction. This figure is largest when the inputs are in phase. The result is latched and announced with a one-clock strobe.

If the first input stops producing rising edges, the block raises an error flag in place of a result. A clear input aborts any measurement and returns every output to zero.

Top module: `xor_phase_meter`

## Requirements
- R1: After reset, `similarity` is 0, `result_valid` is 0 and `timeout_err` is 0.
- R2: A window starts at the first synchronized rising edge of `osc_a` after `start`. It spans exactly the number of `osc_a` cycles latched from `win_cycles`, and its sample total equals that many periods.
- R3: The result is floor(65536 × (total − mismatched) / total), with mismatched being the count of samples where the synchronized `osc_a` and `osc_b` differ. The value is written to `similarity` as unsigned Q0.16.
- R4: When the inputs are identical, so that no samples mismatch, the result saturates to 16'hFFFF. A full mismatch gives 0.
- R5: A `win_cycles` value of 0 behaves exactly like a value of 1.
- R6: `result_valid` is high for exactly one clock per completed window, in the same cycle that `similarity` takes its new value.
- R7: `similarity` holds its value between strobes.
- R8: `start` is ignored while a measurement or division is in progress. `win_cycles` is sampled only when a measurement starts, so neither the result nor the completion time changes.
- R9: If no rising edge of `osc_a` is seen for `TIMEOUT` consecutive samples, the block behaves as follows:
  - This applies both while waiting for the first edge and inside a window.
  - `timeout_err` rises and stays high, no strobe is issued, and `similarity` is left unchanged.
  - The next `start` clears the flag.
- R10: `clear` aborts any measurement, and in the next cycle `similarity` and `timeout_err` read 0. No strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_a | input | 1 | Thresholded first waveform, asynchronous; its rising edges mark cycles |
| osc_b | input | 1 | Thresholded second waveform, asynchronous |
| win_cycles | input | CYC_W | Window length in oscillator cycles, sampled at start (0 means 1) |
| start | input | 1 | Begin a measurement when idle |
| clear | input | 1 | Abort and zero the outputs |
| similarity | output | 16 | One minus average XOR duty, unsigned Q0.16 |
| result_valid | output | 1 | One-clock strobe when similarity is updated |
| timeout_err | output | 1 | Missing-edge error, held until start or clear |

## Verification
A sample counter that drifts, or a window boundary taken one sample early or late, leaves the window without whole periods. The reported fraction then moves off its exact arithmetic value for some phase offsets, and this shows at the first strobe. Because the value does not depend on the window length, a wrong window-cycle count is caught through completion time: the strobe arrives outside the bound set by the latched length. A faulty gap timer shows up as a missing or spurious error flag within about one timeout interval.

// File: rtl/xor_phase_pkg.sv
// Package: shared state encoding and the fixed fraction width.
package xor_phase_pkg;
    localparam int FRAC_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_RUN  = 2'd2,
        PH_DIV  = 2'd3
    } ph_state_t;
endpackage

// File: rtl/xph_front.sv
// Front end: brings both thresholded bits into the clock domain through
// two flops each, flags rising edges of the first bit and forms the XOR.
// Assumes both inputs are asynchronous and slow relative to clk.
module xph_front (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_a,
    input  logic raw_b,
    output logic edge_a,
    output logic xor_bit
);
    logic a_m, a_s, a_d;
    logic b_m, b_s;

    // Two-flop synchronizers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_m <= 1'b0; a_s <= 1'b0; a_d <= 1'b0;
            b_m <= 1'b0; b_s <= 1'b0;
        end else begin
            a_m <= raw_a; a_s <= a_m; a_d <= a_s;
            b_m <= raw_b; b_s <= b_m;
        end
    end

    assign edge_a  = a_s & ~a_d;
    assign xor_bit = a_s ^ b_s;

    AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        edge_a |=> !edge_a); // R2
endmodule

// File: rtl/xph_tally.sv
// Tally: counts window samples and mismatched samples. Load seeds the
// counts with the first sample; inc adds one more. Assumes the caller
// bounds the window so that CNT_W bits never wrap.
module xph_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    input  logic             xbit,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] mism
);
    // Sample and mismatch counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            mism  <= '0;
        end else if (load) begin
            total <= CNT_W'(1);
            mism  <= CNT_W'(xbit);
        end else if (inc) begin
            total <= total + CNT_W'(1);
            mism  <= mism + CNT_W'(xbit);
        end
    end

    AST_MISM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        mism <= total); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (total != '0)); // R2
endmodule

// File: rtl/xph_divider.sv
// Divider: restoring long division, one quotient bit per clock.
// Takes NUM_W clocks after go and pulses done with the quotient.
// Assumes den is nonzero; abort drops any division in progress.
module xph_divider #(
    parameter int DEN_W = 16,
    parameter int NUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quot,
    output logic             done,
    output logic             busy
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  num_sh;
    logic [DEN_W-1:0]  rem;
    logic [DEN_W-1:0]  den_r;
    logic [STEP_W-1:0] steps;
    logic [DEN_W:0]    trial;
    logic              fits;

    assign trial = {rem, num_sh[NUM_W-1]};
    assign fits  = (trial >= {1'b0, den_r});

    // Iterative shift-subtract with one-clock done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            num_sh <= '0; rem <= '0; den_r <= '0; quot <= '0;
            steps <= '0; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                num_sh <= num;
                den_r  <= den;
                rem    <= '0;
                quot   <= '0;
                steps  <= STEP_W'(NUM_W);
                busy   <= 1'b1;
            end else if (busy) begin
                rem    <= fits ? DEN_W'(trial - {1'b0, den_r}) : DEN_W'(trial);
                quot   <= {quot[NUM_W-2:0], fits};
                num_sh <= num_sh << 1;
                steps  <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < den_r)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
endmodule

// File: rtl/xor_phase_meter.sv
// Top: sequences a measurement window over whole cycles of osc_a, times
// out on missing edges, divides the tallies and latches the similarity.
// Assumes osc_a and osc_b are frequency locked and thresholded.
module xor_phase_meter
    import xor_phase_pkg::*;
#(
    parameter int CYC_W   = 8,
    parameter int TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_a,
    input  logic              osc_b,
    input  logic [CYC_W-1:0]  win_cycles,
    input  logic              start,
    input  logic              clear,
    output logic [FRAC_W-1:0] similarity,
    output logic              result_valid,
    output logic              timeout_err
);
    localparam int TO_W  = $clog2(TIMEOUT + 1);
    localparam int CNT_W = CYC_W + TO_W + 1;
    localparam int NUM_W = CNT_W + FRAC_W;

    ph_state_t        st;
    logic             edge_a, xor_bit;
    logic [CYC_W-1:0] w_lat;
    logic [CYC_W-1:0] cyc_cnt;
    logic [TO_W-1:0]  gap;
    logic [CNT_W-1:0] total, mism;
    logic [NUM_W-1:0] quot;
    logic             div_done, div_busy;
    logic             seed, inc, win_end, gap_exp, waiting;

    xph_front u_front (
        .clk(clk), .rst_n(rst_n), .raw_a(osc_a), .raw_b(osc_b),
        .edge_a(edge_a), .xor_bit(xor_bit)
    );

    assign waiting = (st == PH_ARM) || (st == PH_RUN);
    assign seed    = (st == PH_ARM) && edge_a && !clear;
    assign win_end = (st == PH_RUN) && edge_a &&
                     ({1'b0, cyc_cnt} + (CYC_W+1)'(1) == {1'b0, w_lat});
    assign inc     = (st == PH_RUN) && !win_end && !clear;
    assign gap_exp = waiting && !edge_a && (gap == TO_W'(TIMEOUT - 1));

    xph_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .load(seed), .inc(inc), .xbit(xor_bit),
        .total(total), .mism(mism)
    );

    xph_divider #(.DEN_W(CNT_W), .NUM_W(NUM_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(win_end && !clear), .abort(clear),
        .num({total - mism, FRAC_W'(0)}), .den(total),
        .quot(quot), .done(div_done), .busy(div_busy)
    );

    // Control sequencer, window-cycle counter and edge-gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st <= PH_IDLE; w_lat <= '0; cyc_cnt <= '0; gap <= '0;
        end else begin
            case (st)
                PH_IDLE: if (start) begin
                    st      <= PH_ARM;
                    w_lat   <= (win_cycles == '0) ? CYC_W'(1) : win_cycles;
                    cyc_cnt <= '0;
                    gap     <= '0;
                end
                PH_ARM, PH_RUN: begin
                    if (gap_exp) begin
                        st <= PH_IDLE;
                    end else if (edge_a) begin
                        gap <= '0;
                        if (st == PH_ARM)  st <= PH_RUN;
                        else if (win_end)  st <= PH_DIV;
                        else               cyc_cnt <= cyc_cnt + CYC_W'(1);
                    end else begin
                        gap <= gap + TO_W'(1);
                    end
                end
                PH_DIV: if (div_done) st <= PH_IDLE;
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Result register with saturation, strobe and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            similarity <= '0; result_valid <= 1'b0; timeout_err <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (st == PH_IDLE && start) timeout_err <= 1'b0;
            if (gap_exp) timeout_err <= 1'b1;
            if (st == PH_DIV && div_done) begin
                similarity   <= (quot > NUM_W'({FRAC_W{1'b1}})) ? {FRAC_W{1'b1}}
                                                              : quot[FRAC_W-1:0];
                result_valid <= 1'b1;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st == PH_DIV && div_done) && !clear) |=> $stable(similarity)); // R7
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !result_valid); // R9
    AST_DIV_ONLY_IN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (st == PH_DIV)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (similarity == '0 && !timeout_err && !result_valid)); // R10
endmodule

// File: tb/sim_xor_phase_meter.sv
module sim_xor_phase_meter;
    localparam int CYC_W   = 4;
    localparam int TIMEOUT = 64;
    localparam int NUM_W   = CYC_W + $clog2(TIMEOUT + 1) + 1 + 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_a = 1'b0, osc_b = 1'b0;
    logic [CYC_W-1:0] win_cycles = '0;
    logic        start = 1'b0, clear = 1'b0;
    logic [15:0] similarity;
    logic        result_valid, timeout_err;

    int checks = 0, errors = 0;
    int gp = 4, gh = 2, gd = 0;
    bit gen_on = 1'b0;
    int ph = 0;

    always #10 clk = ~clk;

    xor_phase_meter #(.CYC_W(CYC_W), .TIMEOUT(TIMEOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b),
        .win_cycles(win_cycles), .start(start), .clear(clear),
        .similarity(similarity), .result_valid(result_valid),
        .timeout_err(timeout_err)
    );

    // Waveform generator, driven away from the active edge.
    always @(negedge clk) begin
        if (gen_on) begin
            osc_a <= (ph < gh);
            osc_b <= (((ph + gp - gd) % gp) < gh);
            ph    <= (ph + 1) % gp;
        end else begin
            osc_a <= 1'b0;
            osc_b <= 1'b0;
        end
    end

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_sim(input int p, input int h, input int d);
        int xc = 0;
        longint v;
        for (int k = 0; k < p; k++)
            xc += int'((k < h) ^ (((k + p - d) % p) < h));
        v = (longint'(p - xc) * 65536) / p;
        if (v > 65535) v = 65535;
        return int'(v);
    endfunction

    task automatic pulse_start(input int w);
        @(negedge clk); win_cycles = CYC_W'(w); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Waits for a strobe; returns cycles waited, or -1 on error/limit.
    task automatic wait_result(input int limit, output int cyc);
        cyc = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (result_valid) begin cyc = i; return; end
            if (timeout_err) return;
        end
    endtask

    task automatic run_case(input int p, input int h, input int d, input int w,
                            input string req);
        int cyc, weff, bound;
        weff  = (w == 0) ? 1 : w;
        bound = 4 + p + weff * p + NUM_W + 4;
        gp = p; gh = h; gd = d; gen_on = 1'b1;
        repeat (p + 3) @(negedge clk);
        pulse_start(w);
        wait_result(bound, cyc);
        chk({req, " strobe within bound"}, longint'(cyc > 0), 1);
        chk({req, " value"}, similarity, expect_sim(p, h, d));
        @(negedge clk);
        chk("R6 strobe one cycle", result_valid, 0);
    endtask

    initial begin
        int cyc;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk("R1 similarity reset", similarity, 0);
        chk("R1 valid reset", result_valid, 0);
        chk("R1 err reset", timeout_err, 0);
        rst_n = 1'b1;

        // R2/R3 sweep of period, phase offset and window length.
        for (int p = 4; p <= 8; p += 2)
            for (int d = 0; d < p; d++)
                for (int w = 1; w <= 3; w += 2)
                    run_case(p, p / 2, d, w, "R3 sweep");
        run_case(6, 2, 3, 2, "R2 asym duty");
        run_case(5, 2, 1, 4, "R2 odd period");

        // R4: in phase saturates; full opposition gives zero.
        run_case(8, 4, 0, 2, "R4 in phase");
        chk("R4 saturated value", similarity, 16'hFFFF);
        run_case(8, 4, 4, 2, "R4 opposed");
        chk("R4 zero value", similarity, 0);

        // R5: window length zero acts as one.
        run_case(6, 3, 2, 0, "R5 zero window");

        // R7: result holds between strobes.
        held = similarity;
        repeat (40) @(negedge clk);
        chk("R7 hold", similarity, held);

        // R8: second start and new length mid-run are ignored.
        gp = 6; gh = 3; gd = 1; gen_on = 1'b1;
        repeat (9) @(negedge clk);
        pulse_start(2);
        repeat (5) @(negedge clk);
        pulse_start(7);
        wait_result(4 + 6 + 2 * 6 + NUM_W + 4 - 7, cyc);
        chk("R8 start ignored timing", longint'(cyc > 0), 1);
        chk("R8 start ignored value", similarity, expect_sim(6, 3, 1));

        // R9: no edges before the window.
        gen_on = 1'b0;
        repeat (10) @(negedge clk);
        held = similarity;
        pulse_start(2);
        wait_result(TIMEOUT + 20, cyc);
        chk("R9 no strobe", longint'(cyc), -1);
        chk("R9 err set", timeout_err, 1);
        chk("R9 similarity kept", similarity, held);
        repeat (10) @(negedge clk);
        chk("R9 err held", timeout_err, 1);

        // R9: edges stop inside a window; restart clears the flag.
        gp = 8; gh = 4; gd = 2; gen_on = 1'b1;
        repeat (11) @(negedge clk);
        pulse_start(8);
        @(negedge clk);
        chk("R9 start clears err", timeout_err, 0);
        repeat (20) @(negedge clk);
        gen_on = 1'b0;
        wait_result(TIMEOUT + 20, cyc);
        chk("R9 mid-window no strobe", longint'(cyc), -1);
        chk("R9 mid-window err", timeout_err, 1);

        // R10: clear during a window zeroes outputs, no strobe follows.
        run_case(4, 2, 1, 1, "R10 setup");
        gen_on = 1'b1;
        pulse_start(3);
        repeat (6) @(negedge clk);
        clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        chk("R10 similarity zero", similarity, 0);
        chk("R10 err zero", timeout_err, 0);
        wait_result(100, cyc);
        chk("R10 no strobe after clear", longint'(cyc), -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule